// File: doc/BRIEF.md
# Clock Generator Control Register Bank with I2C Slave

This block holds the control bytes of a clock generator and exposes them to an I2C controller. Each bit of a control byte switches one clock output on or off, and the remaining fields pick frequency and spread-spectrum settings. After reset every register holds all ones, so every clock runs without any bus traffic. The current register contents are presented in parallel on `ctrl_o` to the clock-generation logic.

The bus lines are oversampled by the block's own system clock. A write frame carries the slave address, then two bytes that are acknowledged and thrown away, then data bytes that fill registers from register 0 upward. A read frame returns registers from register 0 upward as soon as the address has been acknowledged. There is no register offset: to change register k, the controller resends registers 0 to k-1 as well. SDA is open-drain, modelled as a drive-low enable.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: After reset, every bit of `ctrl_o` is 1, and `sda_drive_low_o` is 0.
- R2: The slave answers only to the 7-bit address 1101001, sent MSB first with R/W as bit 0 (0xD2 write, 0xD3 read). Any other address gets no acknowledge, and the slave then leaves SDA released and changes no register until the next start.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start received in the middle of a frame (repeated start) begins a new address byte.
- R4: In a write frame the two bytes after the address are acknowledged and have no effect. Data byte n, MSB first, lands in register n, which appears on `ctrl_o[8n+7:8n]`.
- R5: Registers that a write frame does not reach keep their earlier values.
- R6: Data bytes written past the last register are acknowledged and discarded.
- R7: In a read frame the slave sends register 0, 1, 2, ... MSB first, starting straight after the address acknowledge, while the controller acknowledges each byte.
- R8: Reads past the last register return 0xFF.
- R9: After the controller answers a read byte with NACK, the slave keeps SDA released until the next start or stop, even if SCL keeps toggling.
- R10: The slave pulls SDA low for the acknowledge in the ninth clock of every byte it accepts, and it changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus (wired-AND level) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ctrl_o | output | 8*NUM_REGS | Control registers, register n in bits [8n+7:8n] |

## Verification
A register write and the acknowledge drive for the same byte start in the same system clock, the SCL falling edge after the eighth bit. The bench keeps a behavioural model of the register file, updated per frame, and compares it with `ctrl_o` on every clock while the bus is idle, so a write that is lost, misplaced or takes place at a wrong time is visible. Each byte's acknowledge is sampled from the wired-AND SDA in the middle of the ninth SCL high phase. A monitor flags any change of the SDA drive while SCL is high.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } ctl_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } rx_phase_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned NUM_LINES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] line_o,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        meta_q <= line_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign line_o[g] = sync_q;
    assign rise_o[g] = sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q & prev_q;
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_s_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // SDA edge while SCL is high marks a bus condition
  assign start_o = scl_s_i & sda_fall_i;
  assign stop_o  = scl_s_i & sda_rise_i;
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
  parameter int unsigned           NUM_REGS = 8,
  parameter logic [8*NUM_REGS-1:0] RST_VAL  = '1,
  localparam int unsigned          IDX_W    = $clog2(NUM_REGS) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [8*NUM_REGS-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     val_q <= RST_VAL[8*g +: 8];
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))     val_q <= wr_data_i;
    end
    assign regs_o[8*g +: 8] = val_q;
  end

  // out-of-range index reads as all ones
  always_comb begin
    rd_data_o = 8'hFF;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_idx_i == IDX_W'(k)) rd_data_o = regs_o[8*k +: 8];
    end
  end
endmodule

// File: rtl/i2c_ctrl_fsm.sv
module i2c_ctrl_fsm
  import clkctl_pkg::*;
#(
  parameter logic [6:0]   SLAVE_ADDR = 7'b1101001,
  parameter int unsigned  NUM_REGS   = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_drive_low_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

  ctl_state_e       state_q;
  rx_phase_e        phase_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic [IDX_W-1:0] idx_q;
  logic             rw_q;
  logic             more_q;
  logic             byte_end;

  function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v);
    return (v == IDX_END) ? v : v + 1'b1;
  endfunction

  assign byte_end = scl_fall_i && (bit_cnt_q == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      rw_q      <= 1'b0;
      more_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_RX;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      rw_q      <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i && bit_cnt_q < 4'd8) begin
            sh_q      <= {sh_q[6:0], sda_s_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_end) begin
            unique case (phase_q)
              PH_ADDR: begin
                if (sh_q[7:1] == SLAVE_ADDR) begin
                  rw_q    <= sh_q[0];
                  state_q <= ST_RX_ACK;
                  phase_q <= PH_CMD;
                end else begin
                  state_q <= ST_WAIT;
                end
              end
              PH_CMD: begin
                state_q <= ST_RX_ACK;
                phase_q <= PH_CNT;
              end
              PH_CNT: begin
                state_q <= ST_RX_ACK;
                phase_q <= PH_DATA;
              end
              default: begin
                state_q <= ST_RX_ACK;
                idx_q   <= sat_inc(idx_q);
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_TX;
              sh_q    <= rd_data_i;
              idx_q   <= sat_inc(idx_q);
            end else begin
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i && bit_cnt_q < 4'd8) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_end) begin
            state_q <= ST_TX_ACK;
          end else if (scl_fall_i) begin
            sh_q <= {sh_q[6:0], 1'b1};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            more_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (more_q) begin
              state_q   <= ST_TX;
              sh_q      <= rd_data_i;
              bit_cnt_q <= '0;
              idx_q     <= sat_inc(idx_q);
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_low_o = (state_q == ST_RX_ACK) || ((state_q == ST_TX) && !sh_q[7]);

  assign wr_en_o   = (state_q == ST_RX) && byte_end && (phase_q == PH_DATA) &&
                     (idx_q != IDX_END) && !start_i && !stop_i;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = sh_q;
  assign rd_idx_o  = idx_q;
endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs #(
  parameter int unsigned           NUM_REGS   = 8,
  parameter logic [6:0]            SLAVE_ADDR = 7'b1101001,
  parameter logic [8*NUM_REGS-1:0] RST_VAL    = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low_o,
  output logic [8*NUM_REGS-1:0] ctrl_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS) + 1;

  logic [1:0]       line_s, line_rise, line_fall;
  logic             scl_s, sda_s;
  logic             start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  i2c_line_sync #(.NUM_LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({sda_i, scl_i}),
    .line_o (line_s),
    .rise_o (line_rise),
    .fall_o (line_fall)
  );

  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2c_cond_detect u_cond (
    .scl_s_i    (scl_s),
    .sda_rise_i (line_rise[1]),
    .sda_fall_i (line_fall[1]),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_ctrl_fsm #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .NUM_REGS   (NUM_REGS)
  ) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sda_s_i         (sda_s),
    .scl_rise_i      (line_rise[0]),
    .scl_fall_i      (line_fall[0]),
    .start_i         (start_det),
    .stop_i          (stop_det),
    .rd_data_i       (rd_data),
    .sda_drive_low_o (sda_drive_low_o),
    .wr_en_o         (wr_en),
    .wr_idx_o        (wr_idx),
    .wr_data_o       (wr_data),
    .rd_idx_o        (rd_idx)
  );

  ctrl_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .RST_VAL  (RST_VAL)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .regs_o    (ctrl_o)
  );
endmodule

// File: rtl/clkgen_ctrl_regs_chk.sv
module clkgen_ctrl_regs_chk #(
  parameter int unsigned NUM_REGS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic                  sda_drive_low_o,
  input logic [8*NUM_REGS-1:0] ctrl_o
);
  // R3: a start always leaves the line released for the new address byte
  assert_start_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_drive_low_o);

  // R9: a stop always leaves the line released
  assert_stop_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_drive_low_o);

  // R10: drive changes only in the SCL low phase
  assert_drive_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_drive_low_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R5: registers move only on a write strobe
  assert_regs_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(ctrl_o));

  // R4: a register write happens during the SCL low phase, never beside a bus condition
  assert_write_timing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (!scl_s && !start_det && !stop_det));
endmodule

bind clkgen_ctrl_regs clkgen_ctrl_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .scl_s           (scl_s),
  .start_det       (start_det),
  .stop_det        (stop_det),
  .wr_en           (wr_en),
  .sda_drive_low_o (sda_drive_low_o),
  .ctrl_o          (ctrl_o)
);

// File: tb/tb_clkgen_ctrl_regs.sv
`timescale 1ns/1ps
module tb_clkgen_ctrl_regs;
  localparam int NREG = 8;
  localparam int HP   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scl_m = 1'b1;
  logic            sda_m = 1'b1;
  logic            sda_bus;
  logic            drive_low;
  logic [8*NREG-1:0] ctrl;

  int checks = 0;
  int errors = 0;
  int r10_viol = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] model [NREG];
  logic prev_drive = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~drive_low;

  clkgen_ctrl_regs dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .scl_i           (scl_m),
    .sda_i           (sda_bus),
    .sda_drive_low_o (drive_low),
    .ctrl_o          (ctrl)
  );

  function automatic logic [8*NREG-1:0] packed_model();
    logic [8*NREG-1:0] v;
    for (int k = 0; k < NREG; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the register file against the model while idle (R4, R5, R6)
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      checks++;
      if (ctrl !== packed_model()) begin
        errors++;
        $display("FAIL R5 regs actual=%h expected=%h", ctrl, packed_model());
      end
    end
  end

  // R10 monitor: drive may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && (drive_low !== prev_drive) && scl_m) r10_viol++;
    prev_drive <= drive_low;
  end

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b0; hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl_m = 1'b1; hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp();
      scl_m = 1'b1; hp();
      scl_m = 1'b0; hp();
    end
    sda_m = 1'b1; hp();
    scl_m = 1'b1;
    repeat (HP/2) @(negedge clk);
    ack = sda_bus;
    repeat (HP/2) @(negedge clk);
    scl_m = 1'b0; hp();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; hp();
      scl_m = 1'b1;
      repeat (HP/2) @(negedge clk);
      b[i] = sda_bus;
      repeat (HP/2) @(negedge clk);
      scl_m = 1'b0; hp();
    end
    sda_m = nack; hp();
    scl_m = 1'b1; hp();
    scl_m = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  task automatic write_frame(input logic [7:0] data[$]);
    logic ack;
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, ack); check("R2 write addr ack", 64'(ack), 64'd0);
    send_byte(8'h3C, ack); check("R4 command ack", 64'(ack), 64'd0);
    send_byte(8'hC5, ack); check("R4 count ack", 64'(ack), 64'd0);
    foreach (data[i]) begin
      send_byte(data[i], ack);
      if (i < NREG) check("R4 data ack", 64'(ack), 64'd0);
      else          check("R6 past-end ack", 64'(ack), 64'd0);
    end
    bus_stop();
    foreach (data[i]) if (i < NREG) model[i] = data[i];
    hp();
    cmp_en = 1'b1;
    hp();
  endtask

  task automatic read_frame(input int n);
    logic ack;
    logic [7:0] b;
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD3, ack); check("R2 read addr ack", 64'(ack), 64'd0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      if (i < NREG) check("R7 read data", 64'(b), 64'(model[i]));
      else          check("R8 past-end read", 64'(b), 64'hFF);
    end
    bus_stop();
    hp();
    cmp_en = 1'b1;
    hp();
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    for (int k = 0; k < NREG; k++) model[k] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset ctrl", 64'(ctrl), 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 reset drive", 64'(drive_low), 64'd0);
    cmp_en = 1'b1;

    // R4: full write, R7: full read
    write_frame('{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF});
    read_frame(NREG);

    // R5: partial write changes only the first bytes
    write_frame('{8'h00, 8'h80, 8'h5A});
    read_frame(4);

    // R6: writes beyond the last register, R8: reads beyond it
    write_frame('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA, 8'hBB});
    read_frame(NREG + 3);

    // R2: wrong address gets no ack, following bytes ignored
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hA4, ack); check("R2 wrong addr nack", 64'(ack), 64'd1);
    send_byte(8'h00, ack); check("R2 ignored byte nack", 64'(ack), 64'd1);
    send_byte(8'h00, ack); check("R2 ignored byte nack", 64'(ack), 64'd1);
    send_byte(8'h00, ack); check("R2 ignored data nack", 64'(ack), 64'd1);
    bus_stop();
    hp();
    check("R2 regs unchanged", 64'(ctrl), 64'(packed_model()));
    cmp_en = 1'b1;
    hp();

    // R3: repeated start mid-write restarts address reception as a read
    cmp_en = 1'b0;
    bus_start();
    send_byte(8'hD2, ack); check("R3 first addr ack", 64'(ack), 64'd0);
    send_byte(8'h00, ack); check("R3 command ack", 64'(ack), 64'd0);
    bus_start();
    send_byte(8'hD3, ack); check("R3 restart addr ack", 64'(ack), 64'd0);
    recv_byte(1'b0, b); check("R3 read after restart", 64'(b), 64'(model[0]));
    // R9: NACK, then further clocks must see a released line
    recv_byte(1'b1, b); check("R7 second byte", 64'(b), 64'(model[1]));
    recv_byte(1'b1, b); check("R9 released after nack", 64'(b), 64'hFF);
    check("R9 no drive after nack", 64'(drive_low), 64'd0);
    bus_stop();
    hp();
    check("R3 regs unchanged", 64'(ctrl), 64'(packed_model()));
    cmp_en = 1'b1;
    hp();

    // R4: bytes after a new write land from register 0 again
    write_frame('{8'hF0, 8'h0F});
    read_frame(2);

    check("R10 drive moved only with SCL low", 64'(r10_viol), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule